// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a 16-bit interval timer that counts down, controlled through a small byte-wide register port. Software first stages a 16-bit reload value through a high-byte port and a low-byte port. It then writes the control register to transfer that value into the counter and to enable counting. While the timer is enabled, a prescaler divides the CPU clock by 16 or by 2, and each prescaled tick takes one from the count.

When the count passes from one to zero, a sticky timeout flag in the status register is set. The count then wraps to 0xFFFF and keeps decrementing. Software clears the flag either by writing a one to it or by stopping the timer. Reads from the two byte ports return the live counter value, so software can poll the remaining time without stopping the timer.

Top module: `ptmr`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) both read 0x00.
- R2: Writes to address 2 store bits 15:8 of a holding register, and writes to address 3 store bits 7:0. These writes leave the live count untouched. Reads from address 2 and address 3 return bits 15:8 and bits 7:0 of the live counter.
- R3: Writing control bit 6 (load) as 1 copies the holding register into the counter on the following clock edge. Bit 6 reads back as 1 for exactly one cycle after that write, then returns to 0 by itself.
- R4: Control bit 5 (rate) selects the tick period: 0 gives one decrement every 16 clocks, 1 gives one decrement every 2 clocks.
- R5: While control bit 7 (run) is 1, the counter decrements from its current value. Writing 0 to run halts the counter, and the count is kept.
- R6: The prescaler restarts on a load and when run rises, so the first decrement always comes one full tick period later. After a write that asserts run and load together, the load is applied first, and the first decrement lands one full tick period after the counter is loaded.
- R7: Status bit 7 (timeout) is set on the tick that takes the count from 1 to 0. It stays set until it is cleared.
- R8: Writing status with bit 7 = 1 clears the timeout flag. Writing status with bit 7 = 0 has no effect on it.
- R9: Any control write with run = 0 clears the timeout flag. A control write with run = 1 does not clear it.
- R10: The rate bit is ignored on a control write made while run is already 1. It is accepted while the timer is stopped, including on a write that sets run and load together.
- R11: A tick taken at count 0 wraps the counter to 0xFFFF, and counting continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 count high, 3 count low |
| we_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register, combinational |

## Verification
The hardest situation to reach is a timeout that coincides with other traffic. Examples are the tick that takes the count from 1 to 0 arriving close to a stop or a clear write, and the wrap past zero while the flag is still held. Because of the prescaler, the count at which these events fall moves with every register access. The stimulus therefore loads very small values under the fast rate and counts every clock edge that each bus access spends, including the edges spent inside writes. This places the zero crossing, the wrap and the clear writes in known cycles. Random trials add mixed reload values and wait lengths at both rates around these directed cases.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STAT   = 2'd1,
    REG_CNT_HI = 2'd2,
    REG_CNT_LO = 2'd3
  } ptmr_reg_e;

  localparam int unsigned BIT_RUN  = 7;
  localparam int unsigned BIT_LOAD = 6;
  localparam int unsigned BIT_RATE = 5;
  localparam int unsigned BIT_TOUT = 7;
endpackage

// File: rtl/ptmr_prescale.sv
`timescale 1ns/1ps
module ptmr_prescale #(
  parameter int unsigned SLOW_DIV = 16,
  parameter int unsigned FAST_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int unsigned PW      = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] last;

  assign last   = fast_i ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
  assign tick_o = run_i && !restart_i && (pre_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (run_i)     pre_q <= (pre_q == last) ? '0 : pre_q + PW'(1);
  end

  // R4: both divisors are at least 2, so ticks never come back to back
  a_r4_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R6: a restart always leaves the prescaler at phase zero
  a_r6_restart_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pre_q == '0));
endmodule

// File: rtl/ptmr_count.sv
`timescale 1ns/1ps
module ptmr_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_hit_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= hold_i;
    else if (tick_i) count_q <= count_q - CNT_W'(1);
  end

  assign count_o    = count_q;
  assign zero_hit_o = tick_i && !load_i && (count_q == CNT_W'(1));

  a_r3_load_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q == $past(hold_i)));
  a_r5_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(count_q));
  a_r11_step_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (count_q == $past(count_q) - CNT_W'(1)));
endmodule

// File: rtl/ptmr.sv
`timescale 1ns/1ps
module ptmr
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SLOW_DIV = 16,
  parameter int unsigned FAST_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic             run_q, load_q, fast_q, tout_q;
  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] count;
  logic             ctrl_wr, stat_wr, start_rise, restart, stop_clr, w1c;
  logic             tick, zero_hit;

  assign ctrl_wr    = we_i && (addr_i == REG_CTRL);
  assign stat_wr    = we_i && (addr_i == REG_STAT);
  assign start_rise = ctrl_wr && wdata_i[BIT_RUN] && !run_q;
  assign restart    = start_rise || load_q;
  assign stop_clr   = ctrl_wr && !wdata_i[BIT_RUN];
  assign w1c        = stat_wr && wdata_i[BIT_TOUT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      load_q <= 1'b0;
      fast_q <= 1'b0;
      hold_q <= '0;
    end else begin
      load_q <= ctrl_wr && wdata_i[BIT_LOAD];
      if (ctrl_wr) run_q <= wdata_i[BIT_RUN];
      if (ctrl_wr && !run_q) fast_q <= wdata_i[BIT_RATE];
      if (we_i && addr_i == REG_CNT_HI) hold_q[CNT_W-1 -: DATA_W] <= wdata_i;
      if (we_i && addr_i == REG_CNT_LO) hold_q[DATA_W-1:0]        <= wdata_i;
    end
  end

  // stop wins over a coincident zero crossing; a crossing wins over write-one-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tout_q <= 1'b0;
    else if (stop_clr) tout_q <= 1'b0;
    else if (zero_hit) tout_q <= 1'b1;
    else if (w1c)      tout_q <= 1'b0;
  end

  ptmr_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .restart_i (restart),
    .fast_i    (fast_q),
    .tick_o    (tick)
  );

  ptmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_q),
    .hold_i     (hold_q),
    .tick_i     (tick),
    .count_o    (count),
    .zero_hit_o (zero_hit)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rdata_o[BIT_RUN]  = run_q;
        rdata_o[BIT_LOAD] = load_q;
        rdata_o[BIT_RATE] = fast_q;
      end
      REG_STAT:   rdata_o[BIT_TOUT] = tout_q;
      REG_CNT_HI: rdata_o = count[CNT_W-1 -: DATA_W];
      default:    rdata_o = count[DATA_W-1:0];
    endcase
  end

  a_r3_load_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q || $past(ctrl_wr));
  a_r10_rate_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> $stable(fast_q));
  a_r9_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_clr |=> !tout_q);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tout_q && !ctrl_wr && !stat_wr) |=> tout_q);
  a_r7_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_hit && !stop_clr) |=> tout_q);
endmodule

// File: tb/sim_ptmr.sv
`timescale 1ns/1ps
module sim_ptmr;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;

  int unsigned n_total = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  always #2 clk_i = ~clk_i;

  ptmr u0 (.clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
           .wdata_i(wdata_i), .rdata_o(rdata_o));

  function automatic logic [15:0] exp_count(input logic [15:0] start, input int unsigned dec);
    return start - 16'(dec);
  endfunction

  function automatic bit exp_flag(input logic [15:0] start, input int unsigned dec);
    return (start != 16'd0) && (dec >= int'(start));
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd2, h);
    rd(2'd3, l);
    v = {h, l};
  endtask

  task automatic idle(input int unsigned n);
    repeat (n) @(negedge clk_i);
  endtask

  // load and start together, wait n edges, then check count and flag
  task automatic trial(input logic [15:0] hv, input bit fast, input int unsigned n, input string tag);
    logic [15:0] c;
    logic [7:0]  s;
    int unsigned div, dec;
    div = fast ? 2 : 16;
    wr(2'd0, 8'h00);
    wr(2'd2, hv[15:8]);
    wr(2'd3, hv[7:0]);
    wr(2'd0, 8'hC0 | (8'(fast) << 5));
    idle(n);
    dec = (n - 1) / div;
    rd_cnt(c);
    chk({tag, " count"}, c, exp_count(hv, dec));
    rd(2'd1, s);
    chk("R7 flag", 16'(s), exp_flag(hv, dec) ? 16'h0080 : 16'h0000);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] c;
    void'($urandom(32'd7719));
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    rd(2'd0, d); chk("R1 ctrl reset", 16'(d), 16'h0000);
    rd(2'd1, d); chk("R1 stat reset", 16'(d), 16'h0000);

    // R3 load strobe, R2 holding latch isolation
    wr(2'd2, 8'h12);
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h40);
    rd(2'd0, d); chk("R3 load bit visible", 16'(d), 16'h0040);
    idle(1);
    rd(2'd0, d); chk("R3 load bit self-clears", 16'(d), 16'h0000);
    rd_cnt(c);   chk("R3 count loaded", c, 16'h1234);
    wr(2'd2, 8'hAB);
    rd_cnt(c);   chk("R2 hold write leaves count", c, 16'h1234);
    idle(30);
    rd_cnt(c);   chk("R5 stopped count holds", c, 16'h1234);

    // R4 and R6 prescale boundaries
    trial(16'h0100, 1'b0, 16, "R6 slow edge 16");
    trial(16'h0100, 1'b0, 17, "R4 slow edge 17");
    trial(16'h0100, 1'b1, 2,  "R6 fast edge 2");
    trial(16'h0100, 1'b1, 3,  "R4 fast edge 3");

    // R5 stop keeps count, restart counts on from it
    trial(16'd1000, 1'b1, 20, "R5 run");
    wr(2'd0, 8'h00);
    idle(40);
    rd_cnt(c); chk("R5 stop holds", c, 16'd990);
    wr(2'd0, 8'hA0);
    idle(7);
    rd_cnt(c); chk("R6 restart from held", c, 16'd987);

    // R10 rate lock while running, acceptance while stopped
    wr(2'd0, 8'h80);
    rd(2'd0, d); chk("R10 rate ignored running", 16'(d), 16'h00A0);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h20);
    rd(2'd0, d); chk("R10 rate accepted stopped", 16'(d), 16'h0020);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R10 rate cleared stopped", 16'(d), 16'h0000);

    // R7, R8, R11 around zero
    trial(16'd1, 1'b1, 3, "R7 reach zero");
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R8 write zero no effect", 16'(d), 16'h0080);
    rd_cnt(c);   chk("R11 wrap", c, 16'hFFFF);
    wr(2'd1, 8'h80);
    rd(2'd1, d); chk("R8 write one clears", 16'(d), 16'h0000);

    // R9 stop clears, running rewrite does not
    trial(16'd2, 1'b1, 10, "R9 setup");
    wr(2'd0, 8'hA0);
    rd(2'd1, d); chk("R9 run write keeps flag", 16'(d), 16'h0080);
    wr(2'd0, 8'h00);
    rd(2'd1, d); chk("R9 stop clears flag", 16'(d), 16'h0000);

    // random trials
    for (int i = 0; i < 40; i++) begin
      logic [15:0] hv;
      bit fast;
      int unsigned n;
      hv   = ($urandom % 2) ? 16'($urandom % 24) : 16'($urandom);
      fast = 1'($urandom % 2);
      n    = 1 + ($urandom % 64);
      trial(hv, fast, n, "R4 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule